// File: doc/BRIEF.md
# Branch Penalty Cycle Accountant

This block is a streaming timing model for a 16-bit microcontroller pipeline. It estimates the cost, in state times, of control-flow events. Each cycle it can take one descriptor over a valid/ready handshake. A descriptor gives the kind of branch, whether it was taken, the target address and the successor address, whether the target and the successor are double-word instructions, and whether the instruction just before wrote the status word. One cycle after it takes a descriptor, the block presents the base cost, the added penalty and their sum.

The block applies three penalty rules:

- A double-word target at a misaligned address lengthens a standard jump.
- A cache jump is lengthened only when both the cached target and its successor are misaligned double-word instructions.
- A status-word write immediately before a condition test costs one extra state.

Alongside the per-event results, the block keeps a running saturating sum of all totals and three saturating counters, one for each penalty cause. A synchronous clear zeroes all of them.

Double-word alignment depends on address bit 1 only. An address whose low hex digit is 2, 6, A or E has bit 1 set and is misaligned. Low digits 0, 4, 8 and C are aligned. Instruction decode, fetch and memory timing happen elsewhere.

Top module: `brcost_acct`

## Requirements
- R1: A taken standard jump (kind 2'b00) has base 4. Its penalty is 2 when the target is double-word and target address bit 1 is 1, and 0 otherwise. In every result, total = base + penalty.
- R2: A taken cache jump (kind 2'b01) has base 2. Its penalty is 2 only when both target and successor are double-word with address bit 1 set. Otherwise the penalty is 0.
- R3: A conditional branch (kind 2'b10) adds 1 to its penalty when the previous instruction wrote the status word. When taken, it also has base 4 and the standard-jump misalignment penalty of 2. When not taken, its base is 0.
- R4: Any of the following gives base 0, penalty 0 and total 0: a standard jump not taken, a cache jump not taken, or kind 2'b11.
- R5: Each accepted descriptor (in_valid and in_ready high at a rising edge) gives exactly one result. Results keep their order, and res_valid is high from the edge after acceptance.
- R6: in_ready is low exactly when a result is pending and res_ready is low. While stalled, the result fields stay unchanged until they are taken.
- R7: run_cycles adds the total of every accepted descriptor and saturates at its maximum value.
- R8: Each penalty counter adds 1 per accepted descriptor that incurs its cause, and saturates. cnt_std_mis counts the misalignment penalty of standard jumps and taken conditional branches. cnt_cache_mis counts cache-jump misalignment. cnt_sw_hazard counts status-word hazards.
- R9: clr zeroes run_cycles and all penalty counters at the next edge. clr takes precedence over an event accepted in the same cycle. That event's result is still emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clr | input | 1 | Synchronous clear of the accumulators |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Descriptor can be taken |
| in_kind | input | 2 | 00 standard, 01 cache, 10 conditional, 11 none |
| in_taken | input | 1 | Branch taken |
| in_tgt_addr | input | ADDR_W | Target address |
| in_tgt_dw | input | 1 | Target is double-word |
| in_succ_addr | input | ADDR_W | Successor address |
| in_succ_dw | input | 1 | Successor is double-word |
| in_prev_sw_wr | input | 1 | Previous instruction wrote the status word |
| res_valid | output | 1 | Result pending |
| res_ready | input | 1 | Downstream takes the result |
| res_base | output | COST_W | Base state times |
| res_pen | output | COST_W | Added state times |
| res_total | output | SUM_W | Base plus penalty |
| run_cycles | output | TOT_W | Saturating running total |
| cnt_std_mis | output | CNT_W | Standard misalignment count |
| cnt_cache_mis | output | CNT_W | Cache misalignment count |
| cnt_sw_hazard | output | CNT_W | Status-word hazard count |

## Verification
A result is registered at the edge that accepts its descriptor, so it appears on the res_* fields one cycle later. The accumulators change at that same edge.

The bench drives inputs just after a rising edge and samples on the falling edge. When it sees a handshake at a falling edge, it records the expected result in a queue. The monitor pops that entry on the first falling edge where res_valid and res_ready are both high. The accumulators are compared only after the queue has drained, at which point every accepted event must already be counted.

// File: rtl/brcost_pkg.sv
package brcost_pkg;
   typedef enum logic [1:0] {
      BK_STD   = 2'b00,
      BK_CACHE = 2'b01,
      BK_COND  = 2'b10,
      BK_NONE  = 2'b11
   } br_kind_e;

   // cause slots for the penalty counter array
   localparam int CAUSE_STD   = 0;
   localparam int CAUSE_CACHE = 1;
   localparam int CAUSE_SW    = 2;
   localparam int N_CAUSES    = 3;

   // double-word misalignment: address bit 1 set on a double-word instruction
   function automatic logic dw_misaligned(input logic is_dw, input logic addr_b1);
      return is_dw & addr_b1;
   endfunction
endpackage

// File: rtl/brcost_calc.sv
module brcost_calc
   import brcost_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int COST_W     = 4,
   parameter int SUM_W      = 5,
   parameter int STD_BASE   = 4,
   parameter int CACHE_BASE = 2,
   parameter int MIS_PEN    = 2,
   parameter int SW_PEN     = 1
) (
   input  logic [1:0]        kind,
   input  logic              taken,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic              tgt_dw,
   input  logic [ADDR_W-1:0] succ_addr,
   input  logic              succ_dw,
   input  logic              prev_sw_wr,
   output logic [COST_W-1:0] base,
   output logic [COST_W-1:0] pen,
   output logic [SUM_W-1:0]  total,
   output logic [N_CAUSES-1:0] hits
);
   localparam int ALIGN_BIT = 1;
   localparam logic [COST_W-1:0] C_STD   = COST_W'(STD_BASE);
   localparam logic [COST_W-1:0] C_CACHE = COST_W'(CACHE_BASE);
   localparam logic [COST_W-1:0] C_MIS   = COST_W'(MIS_PEN);
   localparam logic [COST_W-1:0] C_SW    = COST_W'(SW_PEN);

   logic mis_t, mis_s;
   br_kind_e k;

   assign k     = br_kind_e'(kind);
   assign mis_t = dw_misaligned(tgt_dw,  tgt_addr[ALIGN_BIT]);
   assign mis_s = dw_misaligned(succ_dw, succ_addr[ALIGN_BIT]);

   always_comb begin
      base = '0;
      pen  = '0;
      hits = '0;
      unique case (k)
         BK_STD: begin
            if (taken) begin
               base = C_STD;
               if (mis_t) begin
                  pen = C_MIS;
                  hits[CAUSE_STD] = 1'b1;
               end
            end
         end
         BK_CACHE: begin
            if (taken) begin
               base = C_CACHE;
               if (mis_t && mis_s) begin
                  pen = C_MIS;
                  hits[CAUSE_CACHE] = 1'b1;
               end
            end
         end
         BK_COND: begin
            if (prev_sw_wr) begin
               pen = C_SW;
               hits[CAUSE_SW] = 1'b1;
            end
            if (taken) begin
               base = C_STD;
               if (mis_t) begin
                  pen = pen + C_MIS;
                  hits[CAUSE_STD] = 1'b1;
               end
            end
         end
         default: ;
      endcase
   end

   assign total = SUM_W'(base) + SUM_W'(pen);
endmodule

// File: rtl/brcost_satctr.sv
module brcost_satctr #(
   parameter int W        = 16,
   parameter int INC_W    = 1,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [INC_W-1:0] inc,
   output logic [W-1:0]     q
);
   logic [W:0]   sum;
   logic [W-1:0] nxt;

   assign sum = {1'b0, q} + (W+1)'(inc);

   generate
      if (SATURATE) begin : g_sat
         assign nxt = sum[W] ? {W{1'b1}} : sum[W-1:0];
      end else begin : g_wrap
         assign nxt = sum[W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else if (en)  q <= nxt;
   end
endmodule

// File: rtl/brcost_hold.sv
module brcost_hold #(
   parameter int W = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         up_valid,
   output logic         up_ready,
   input  logic [W-1:0] d,
   output logic         dn_valid,
   input  logic         dn_ready,
   output logic [W-1:0] q
);
   assign up_ready = !dn_valid || dn_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dn_valid <= 1'b0;
         q        <= '0;
      end else if (up_valid && up_ready) begin
         dn_valid <= 1'b1;
         q        <= d;
      end else if (dn_ready) begin
         dn_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/brcost_acct.sv
module brcost_acct
   import brcost_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int COST_W     = 4,
   parameter int SUM_W      = 5,
   parameter int TOT_W      = 32,
   parameter int CNT_W      = 16,
   parameter int STD_BASE   = 4,
   parameter int CACHE_BASE = 2,
   parameter int MIS_PEN    = 2,
   parameter int SW_PEN     = 1,
   parameter bit SATURATE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [1:0]        in_kind,
   input  logic              in_taken,
   input  logic [ADDR_W-1:0] in_tgt_addr,
   input  logic              in_tgt_dw,
   input  logic [ADDR_W-1:0] in_succ_addr,
   input  logic              in_succ_dw,
   input  logic              in_prev_sw_wr,
   output logic              res_valid,
   input  logic              res_ready,
   output logic [COST_W-1:0] res_base,
   output logic [COST_W-1:0] res_pen,
   output logic [SUM_W-1:0]  res_total,
   output logic [TOT_W-1:0]  run_cycles,
   output logic [CNT_W-1:0]  cnt_std_mis,
   output logic [CNT_W-1:0]  cnt_cache_mis,
   output logic [CNT_W-1:0]  cnt_sw_hazard
);
   localparam int RES_W    = 2*COST_W + SUM_W;
   localparam int MAX_BASE = (STD_BASE > CACHE_BASE) ? STD_BASE : CACHE_BASE;
   localparam int MAX_PEN  = MIS_PEN + SW_PEN;

   // elaboration-time parameter checks
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("brcost_acct: ADDR_W must reach address bit 1");
      end
      if (MAX_BASE >= (1 << COST_W) || MAX_PEN >= (1 << COST_W)) begin : g_bad_cost
         $error("brcost_acct: COST_W too narrow for base or penalty");
      end
      if (MAX_BASE + MAX_PEN >= (1 << SUM_W)) begin : g_bad_sum
         $error("brcost_acct: SUM_W too narrow for the worst total");
      end
      if (TOT_W < SUM_W || CNT_W < 1) begin : g_bad_acc
         $error("brcost_acct: accumulator widths too small");
      end
   endgenerate

   logic [COST_W-1:0]   c_base, c_pen;
   logic [SUM_W-1:0]    c_total;
   logic [N_CAUSES-1:0] c_hits;
   logic [RES_W-1:0]    res_q;
   logic                accept;

   brcost_calc #(
      .ADDR_W(ADDR_W), .COST_W(COST_W), .SUM_W(SUM_W),
      .STD_BASE(STD_BASE), .CACHE_BASE(CACHE_BASE),
      .MIS_PEN(MIS_PEN), .SW_PEN(SW_PEN)
   ) calc_i (
      .kind(in_kind), .taken(in_taken),
      .tgt_addr(in_tgt_addr), .tgt_dw(in_tgt_dw),
      .succ_addr(in_succ_addr), .succ_dw(in_succ_dw),
      .prev_sw_wr(in_prev_sw_wr),
      .base(c_base), .pen(c_pen), .total(c_total), .hits(c_hits)
   );

   brcost_hold #(.W(RES_W)) hold_i (
      .clk(clk), .rst_n(rst_n),
      .up_valid(in_valid), .up_ready(in_ready),
      .d({c_base, c_pen, c_total}),
      .dn_valid(res_valid), .dn_ready(res_ready),
      .q(res_q)
   );

   assign accept = in_valid && in_ready;
   assign {res_base, res_pen, res_total} = res_q;

   brcost_satctr #(.W(TOT_W), .INC_W(SUM_W), .SATURATE(SATURATE)) run_i (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .en(accept), .inc(c_total), .q(run_cycles)
   );

   logic [CNT_W-1:0] cause_q [N_CAUSES];

   generate
      for (genvar gi = 0; gi < N_CAUSES; gi++) begin : g_cause
         brcost_satctr #(.W(CNT_W), .INC_W(1), .SATURATE(SATURATE)) ctr_i (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .en(accept && c_hits[gi]), .inc(1'b1), .q(cause_q[gi])
         );
      end
   endgenerate

   assign cnt_std_mis   = cause_q[CAUSE_STD];
   assign cnt_cache_mis = cause_q[CAUSE_CACHE];
   assign cnt_sw_hazard = cause_q[CAUSE_SW];
endmodule

// File: rtl/brcost_chk.sv
module brcost_chk #(
   parameter int COST_W     = 4,
   parameter int SUM_W      = 5,
   parameter int TOT_W      = 32,
   parameter int CNT_W      = 16,
   parameter int CACHE_BASE = 2,
   parameter int MIS_PEN    = 2,
   parameter int SW_PEN     = 1,
   parameter bit SATURATE   = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr,
   input logic              in_valid,
   input logic              in_ready,
   input logic              res_valid,
   input logic              res_ready,
   input logic [COST_W-1:0] res_base,
   input logic [COST_W-1:0] res_pen,
   input logic [SUM_W-1:0]  res_total,
   input logic [TOT_W-1:0]  run_cycles,
   input logic [CNT_W-1:0]  cnt_std_mis,
   input logic [CNT_W-1:0]  cnt_cache_mis,
   input logic [CNT_W-1:0]  cnt_sw_hazard
);
   p_total_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> res_total == SUM_W'(res_base) + SUM_W'(res_pen));

   p_cache_pen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_base == COST_W'(CACHE_BASE)) |->
         (res_pen == '0 || res_pen == COST_W'(MIS_PEN)));

   p_pen_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> res_pen <= COST_W'(MIS_PEN + SW_PEN));

   p_result_due_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> res_valid);

   p_stall_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_ready) |-> !in_ready);

   p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_ready) |=>
         (res_valid && $stable(res_base) && $stable(res_pen) && $stable(res_total)));

   p_run_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (SATURATE && !clr) |=> run_cycles >= $past(run_cycles));

   p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((cnt_sw_hazard - $past(cnt_sw_hazard)) <= CNT_W'(1) &&
                (cnt_std_mis   - $past(cnt_std_mis))   <= CNT_W'(1) &&
                (cnt_cache_mis - $past(cnt_cache_mis)) <= CNT_W'(1)));

   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (run_cycles == '0 && cnt_std_mis == '0 &&
               cnt_cache_mis == '0 && cnt_sw_hazard == '0));
endmodule

bind brcost_acct brcost_chk #(
   .COST_W(COST_W), .SUM_W(SUM_W), .TOT_W(TOT_W), .CNT_W(CNT_W),
   .CACHE_BASE(CACHE_BASE), .MIS_PEN(MIS_PEN), .SW_PEN(SW_PEN),
   .SATURATE(SATURATE)
) chk_i (
   .clk(clk), .rst_n(rst_n), .clr(clr),
   .in_valid(in_valid), .in_ready(in_ready),
   .res_valid(res_valid), .res_ready(res_ready),
   .res_base(res_base), .res_pen(res_pen), .res_total(res_total),
   .run_cycles(run_cycles), .cnt_std_mis(cnt_std_mis),
   .cnt_cache_mis(cnt_cache_mis), .cnt_sw_hazard(cnt_sw_hazard)
);

// File: tb/brcost_acct_tb_top.sv
`timescale 1ns/1ps
module brcost_acct_tb_top;
   localparam int TW = 8;
   localparam int CW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0;
   logic in_valid = 1'b0;
   logic [1:0] in_kind = 2'b11;
   logic in_taken = 1'b0;
   logic [15:0] in_tgt_addr = '0, in_succ_addr = '0;
   logic in_tgt_dw = 1'b0, in_succ_dw = 1'b0, in_prev_sw_wr = 1'b0;
   logic res_ready;
   logic in_ready, res_valid;
   logic [3:0] res_base, res_pen;
   logic [4:0] res_total;
   logic [TW-1:0] run_cycles;
   logic [CW-1:0] cnt_std_mis, cnt_cache_mis, cnt_sw_hazard;

   always #2.5 clk = ~clk;

   brcost_acct #(.TOT_W(TW), .CNT_W(CW)) dut_i (.*);

   int n_cmp = 0, n_bad = 0;
   logic [12:0] q_exp[$];
   string       q_tag[$];
   int m_run = 0, m_std = 0, m_cache = 0, m_sw = 0;
   bit stall_lo = 0, rand_rdy = 0;
   logic [15:0] lf_r = 16'hACE1, lf_d = 16'h1D2B;

   function automatic logic [15:0] lfsr(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   task automatic chk(input string tag, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
      end
   endtask

   // downstream ready pattern, updated just after each rising edge
   always @(posedge clk) begin
      #1;
      lf_r = lfsr(lf_r);
      res_ready = stall_lo ? 1'b0 : (rand_rdy ? lf_r[0] : 1'b1);
   end
   initial res_ready = 1'b1;

   // monitor: pop on each falling edge with a completing handshake
   always @(negedge clk) begin
      if (rst_n && res_valid && res_ready) begin
         if (q_exp.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R5: actual unexpected result expected none");
         end else begin
            logic [12:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            chk({t, " base"},  int'(res_base),  int'(e[12:9]));
            chk({t, " pen"},   int'(res_pen),   int'(e[8:5]));
            chk({t, " total"}, int'(res_total), int'(e[4:0]));
         end
      end
   end

   function automatic int sat(input int v, input int w);
      return (v > (1 << w) - 1) ? (1 << w) - 1 : v;
   endfunction

   // expected cost from the requirements, with model accumulator update
   task automatic model(input logic [1:0] k, input logic tk, input logic [15:0] ta,
                        input logic tdw, input logic [15:0] sa, input logic sdw,
                        input logic sw, input string tag, input bit cleared);
      int b = 0, p = 0;
      bit ms = 0, mc = 0, mh = 0;
      case (k)
         2'b00: if (tk) begin b = 4; if (tdw && ta[1]) begin p = 2; ms = 1; end end
         2'b01: if (tk) begin b = 2;
                   if (tdw && ta[1] && sdw && sa[1]) begin p = 2; mc = 1; end end
         2'b10: begin
                   if (sw) begin p = 1; mh = 1; end
                   if (tk) begin b = 4; if (tdw && ta[1]) begin p += 2; ms = 1; end end
                end
         default: ;
      endcase
      q_exp.push_back({4'(b), 4'(p), 5'(b + p)});
      q_tag.push_back(tag);
      if (cleared) begin
         m_run = 0; m_std = 0; m_cache = 0; m_sw = 0;
      end else begin
         m_run   = sat(m_run + b + p, TW);
         m_std   = sat(m_std + int'(ms), CW);
         m_cache = sat(m_cache + int'(mc), CW);
         m_sw    = sat(m_sw + int'(mh), CW);
      end
   endtask

   // driver: called just after a rising edge
   task automatic send(input logic [1:0] k, input logic tk, input logic [15:0] ta,
                       input logic tdw, input logic [15:0] sa, input logic sdw,
                       input logic sw, input string tag, input bit with_clr = 0);
      in_kind = k; in_taken = tk; in_tgt_addr = ta; in_tgt_dw = tdw;
      in_succ_addr = sa; in_succ_dw = sdw; in_prev_sw_wr = sw;
      in_valid = 1'b1; clr = with_clr;
      forever begin
         @(negedge clk);
         if (in_ready) break;
         @(posedge clk); #1;
      end
      model(k, tk, ta, tdw, sa, sdw, sw, tag, with_clr);
      @(posedge clk); #1;
      in_valid = 1'b0; clr = 1'b0;
   endtask

   task automatic drain();
      while (q_exp.size() != 0 || res_valid) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic chk_acc(input string tag);
      @(negedge clk);
      chk({tag, " R7 run_cycles"},    int'(run_cycles),    m_run);
      chk({tag, " R8 cnt_std_mis"},   int'(cnt_std_mis),   m_std);
      chk({tag, " R8 cnt_cache_mis"}, int'(cnt_cache_mis), m_cache);
      chk({tag, " R8 cnt_sw_hazard"}, int'(cnt_sw_hazard), m_sw);
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("reset res_valid", int'(res_valid), 0);
      chk("reset R6 in_ready", int'(in_ready), 1);
      chk("reset R7 run_cycles", int'(run_cycles), 0);
      @(posedge clk); #1;

      // R1 standard jumps
      send(2'b00, 1, 16'h1004, 1, 16'h1008, 0, 0, "R1 std aligned dw");
      send(2'b00, 1, 16'h0FFE, 1, 16'h1002, 0, 0, "R1 std misaligned dw");
      send(2'b00, 1, 16'h0FFE, 0, 16'h1000, 0, 0, "R1 std misaligned single");
      send(2'b00, 1, 16'h200C, 1, 16'h2010, 1, 1, "R1 std aligned low digit C");
      // R2 cache jumps
      send(2'b01, 1, 16'h12FA, 1, 16'h12FE, 1, 0, "R2 cache both misaligned");
      send(2'b01, 1, 16'h12FA, 1, 16'h12FC, 1, 0, "R2 cache target only");
      send(2'b01, 1, 16'h12F8, 1, 16'h12FE, 1, 0, "R2 cache successor only");
      send(2'b01, 1, 16'h12FA, 1, 16'h12FE, 0, 0, "R2 cache successor single");
      // R3 conditional branches
      send(2'b10, 1, 16'h3000, 0, 16'h3002, 0, 1, "R3 cond taken sw");
      send(2'b10, 1, 16'h3006, 1, 16'h300A, 1, 1, "R3 cond taken mis sw");
      send(2'b10, 0, 16'h3006, 1, 16'h300A, 1, 1, "R3 cond not taken sw");
      send(2'b10, 0, 16'h3000, 0, 16'h3002, 0, 0, "R3 cond not taken clean");
      send(2'b10, 1, 16'h3000, 0, 16'h3002, 0, 0, "R3 cond taken clean");
      // R4 zero cost
      send(2'b00, 0, 16'h0FFE, 1, 16'h1002, 1, 1, "R4 std not taken");
      send(2'b01, 0, 16'h12FA, 1, 16'h12FE, 1, 1, "R4 cache not taken");
      send(2'b11, 1, 16'h12FA, 1, 16'h12FE, 1, 1, "R4 kind none");
      drain();
      chk_acc("directed");

      // R5/R6 stall: result held, input blocked
      stall_lo = 1;
      @(posedge clk); #1;
      send(2'b00, 1, 16'h0FFE, 1, 16'h1002, 0, 0, "R6 held result");
      @(negedge clk);
      chk("R5 valid one cycle after accept", int'(res_valid), 1);
      chk("R6 ready low while stalled", int'(in_ready), 0);
      repeat (3) @(negedge clk);
      chk("R6 still pending while stalled", q_exp.size(), 1);
      chk("R6 held base", int'(res_base), 4);
      chk("R6 held pen", int'(res_pen), 2);
      @(posedge clk); #1;
      stall_lo = 0;
      drain();
      chk_acc("after stall");

      // R9 clear together with an accepted event
      send(2'b10, 1, 16'h3006, 1, 16'h300A, 0, 1, "R9 result with clr", 1);
      drain();
      chk_acc("R9 clear");

      // R7/R8 saturation: 40 events of 7 states each
      for (int i = 0; i < 40; i++)
         send(2'b10, 1, 16'h4002, 1, 16'h4006, 0, 1, "R7 saturation stream");
      drain();
      chk_acc("saturated");
      chk("R7 run_cycles at max", int'(run_cycles), 255);
      chk("R8 cnt_sw_hazard at max", int'(cnt_sw_hazard), 15);

      // mixed stream under random backpressure
      send(2'b00, 0, 16'h0, 0, 16'h0, 0, 0, "R9 pre-random clr", 1);
      drain();
      rand_rdy = 1;
      for (int i = 0; i < 30; i++) begin
         lf_d = lfsr(lf_d); lf_d = lfsr(lf_d);
         send(lf_d[1:0], lf_d[2], {lf_d[15:4], 2'b00, lf_d[3], 1'b0}, lf_d[5],
              {lf_d[11:4], lf_d[15:12], 1'b0, lf_d[6], 2'b00}, lf_d[7], lf_d[8],
              "R5 random order");
      end
      drain();
      rand_rdy = 0;
      chk_acc("random");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule